// File: doc/BRIEF.md
# Compare Output Pin Driver

This block keeps the output-compare state bit for one timer channel and decides what the shared port pin shows. Each clock it receives a one-cycle compare-match pulse, a counter-at-bottom pulse, the counting direction, a class of waveform operation and a two-bit action field. It then sets, clears or toggles its state bit, or leaves it unchanged. A force strobe lets the plain, non-PWM class apply the match action without a real match.

When the registered action field is nonzero, the pin value comes from the state bit. Otherwise the pin shows the general port data bit. The pin's output enable always follows the port direction bit. Software can therefore prepare the state bit while the pin is still an input, and then turn the pin to output with no glitch.

Top module: `cmp_pin_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the state bit is 0 and the registered action field is 0. pinOut therefore equals portData.
- R2: The action field is sampled into a register on every rising clock edge. When the registered field is nonzero, pinOut equals the state bit. When it is zero, pinOut equals portData.
- R3: pinOe equals portDir in every cycle, whatever the action field holds.
- R4: With a registered field of 0, a match, a bottom pulse or a force leaves the state bit unchanged.
- R5: In the plain class (modeClass 0), a match with field 1 toggles the state bit, field 2 clears it and field 3 sets it. The new value is visible one cycle later.
- R6: In the plain class, a force strobe applies the same action as a match. A force and a match in the same cycle apply the action only once.
- R7: In the single-slope class (modeClass 1), field 2 clears the state bit on a match and sets it on a bottom pulse. Field 3 does the opposite. When both pulses come in the same cycle, the match action wins.
- R8: In the single-slope class, field 1 causes no change.
- R9: In the dual-slope class (modeClass 2), field 2 clears the state bit on a match while counting up (countDown 0) and sets it on a match while counting down. Field 3 does the inverse. A bottom pulse has no effect.
- R10: In the single-slope and dual-slope classes, the force strobe has no effect.
- R11: A match uses the field that was registered before its clock edge. A field written in the same cycle as a match acts only from the next match on.
- R12: The state bit can be set by a force while portDir is 0. It appears on pinOut, with pinOe high, once portDir goes to 1.
- R13: modeClass 3 is reserved. With it, no input changes the state bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| matchPulse | input | 1 | One-cycle compare-match indication |
| bottomEvt | input | 1 | One-cycle counter-at-bottom indication |
| countDown | input | 1 | Counting direction, 1 = down (used in the dual-slope class) |
| modeClass | input | 2 | 0 plain, 1 single-slope PWM, 2 dual-slope PWM, 3 reserved |
| comField | input | 2 | Action field, 0 disconnected, 1 to 3 as in R5, R7 and R9 |
| forceStrobe | input | 1 | Force a match action (plain class only) |
| portData | input | 1 | General port data bit |
| portDir | input | 1 | Port direction bit, 1 = output |
| pinOut | output | 1 | Value driven to the pin |
| pinOe | output | 1 | Pin output enable |

## Verification
pinOe is a combinational copy of portDir and can be seen in the cycle it is driven. The registered field and the state bit change at the first rising edge after a stimulus, so pinOut reflects a match, force, bottom pulse or field write exactly one edge later. The bench drives each stimulus at a falling edge and predicts the result after the next rising edge. It queues that result, and the monitor compares it 2 ns after that rising edge. Inputs are held until the following falling edge, so the combinational pin values are stable when they are sampled.

// File: rtl/cmp_pin_pkg.sv
package cmp_pin_pkg;
  localparam int FIELD_W = 2;
  localparam int CLASS_W = 2;

  typedef enum logic [CLASS_W-1:0] {
    CLS_PLAIN  = 2'd0,
    CLS_SINGLE = 2'd1,
    CLS_DUAL   = 2'd2,
    CLS_RSVD   = 2'd3
  } modeClass_e;

  typedef enum logic [FIELD_W-1:0] {
    FLD_OFF    = 2'd0,
    FLD_TOGGLE = 2'd1,
    FLD_LOW    = 2'd2,
    FLD_HIGH   = 2'd3
  } fieldCode_e;

  // strobes from control to datapath; at most one is high
  typedef struct packed {
    logic doSet;
    logic doClr;
    logic doTgl;
  } ocStrobe_t;
endpackage

// File: rtl/cmp_pin_ctrl.sv
module cmp_pin_ctrl
  import cmp_pin_pkg::*;
(
  input  logic [FIELD_W-1:0] comReg,
  input  logic [CLASS_W-1:0] modeClass,
  input  logic               matchPulse,
  input  logic               bottomEvt,
  input  logic               countDown,
  input  logic               forceStrobe,
  output ocStrobe_t          strobe
);
  fieldCode_e fld;
  modeClass_e cls;
  logic       plainHit;

  assign fld      = fieldCode_e'(comReg);
  assign cls      = modeClass_e'(modeClass);
  assign plainHit = matchPulse | forceStrobe;

  always_comb begin
    strobe = '0;
    unique case (cls)
      CLS_PLAIN: begin
        if (plainHit) begin
          unique case (fld)
            FLD_TOGGLE: strobe.doTgl = 1'b1;
            FLD_LOW:    strobe.doClr = 1'b1;
            FLD_HIGH:   strobe.doSet = 1'b1;
            default:    strobe = '0;
          endcase
        end
      end
      CLS_SINGLE: begin
        if (matchPulse) begin
          strobe.doClr = (fld == FLD_LOW);
          strobe.doSet = (fld == FLD_HIGH);
        end else if (bottomEvt) begin
          strobe.doSet = (fld == FLD_LOW);
          strobe.doClr = (fld == FLD_HIGH);
        end
      end
      CLS_DUAL: begin
        if (matchPulse) begin
          strobe.doClr = ((fld == FLD_LOW) & ~countDown) | ((fld == FLD_HIGH) & countDown);
          strobe.doSet = ((fld == FLD_LOW) & countDown) | ((fld == FLD_HIGH) & ~countDown);
        end
      end
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/cmp_pin_dp.sv
module cmp_pin_dp
  import cmp_pin_pkg::*;
#(
  parameter bit OC_RESET = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FIELD_W-1:0] comField,
  input  ocStrobe_t          strobe,
  input  logic               portData,
  input  logic               portDir,
  output logic [FIELD_W-1:0] comReg,
  output logic               ocState,
  output logic               pinOut,
  output logic               pinOe
);
  logic ocNext;
  logic override;

  always_comb begin
    ocNext = ocState;
    if (strobe.doSet)      ocNext = 1'b1;
    else if (strobe.doClr) ocNext = 1'b0;
    else if (strobe.doTgl) ocNext = ~ocState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      comReg  <= '0;
      ocState <= OC_RESET;
    end else begin
      comReg  <= comField;
      ocState <= ocNext;
    end
  end

  assign override = |comReg;
  assign pinOut   = override ? ocState : portData;
  assign pinOe    = portDir;
endmodule

// File: rtl/cmp_pin_unit.sv
module cmp_pin_unit
  import cmp_pin_pkg::*;
#(
  parameter bit OC_RESET = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       matchPulse,
  input  logic       bottomEvt,
  input  logic       countDown,
  input  logic [1:0] modeClass,
  input  logic [1:0] comField,
  input  logic       forceStrobe,
  input  logic       portData,
  input  logic       portDir,
  output logic       pinOut,
  output logic       pinOe
);
  ocStrobe_t          strobe;
  logic [FIELD_W-1:0] comReg;
  logic               ocState;

  cmp_pin_ctrl u_ctrl (
    .comReg      (comReg),
    .modeClass   (modeClass),
    .matchPulse  (matchPulse),
    .bottomEvt   (bottomEvt),
    .countDown   (countDown),
    .forceStrobe (forceStrobe),
    .strobe      (strobe)
  );

  cmp_pin_dp #(.OC_RESET(OC_RESET)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .comField (comField),
    .strobe   (strobe),
    .portData (portData),
    .portDir  (portDir),
    .comReg   (comReg),
    .ocState  (ocState),
    .pinOut   (pinOut),
    .pinOe    (pinOe)
  );
endmodule

// File: rtl/cmp_pin_chk.sv
module cmp_pin_chk (
  input logic       clk,
  input logic       rstN,
  input logic       matchPulse,
  input logic       bottomEvt,
  input logic       countDown,
  input logic [1:0] modeClass,
  input logic [1:0] comReg,
  input logic       forceStrobe,
  input logic       portData,
  input logic       ocState,
  input logic       pinOut
);
  // R2
  port_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (comReg == 2'd0) |-> (pinOut == portData));

  // R4
  off_field_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (comReg == 2'd0) |=> (ocState == $past(ocState)));

  // R5
  plain_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeClass == 2'd0 && matchPulse && comReg == 2'd1) |=> (ocState != $past(ocState)));

  // R5
  plain_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeClass == 2'd0 && matchPulse && comReg == 2'd3) |=> ocState);

  // R7
  single_bottom_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeClass == 2'd1 && bottomEvt && !matchPulse && comReg == 2'd2) |=> ocState);

  // R9
  dual_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeClass == 2'd2 && matchPulse && countDown && comReg == 2'd2) |=> ocState);

  // R10
  pwm_force_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeClass != 2'd0 && forceStrobe && !matchPulse && !bottomEvt) |=> $stable(ocState));
endmodule

bind cmp_pin_unit cmp_pin_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .matchPulse  (matchPulse),
  .bottomEvt   (bottomEvt),
  .countDown   (countDown),
  .modeClass   (modeClass),
  .comReg      (comReg),
  .forceStrobe (forceStrobe),
  .portData    (portData),
  .ocState     (ocState),
  .pinOut      (pinOut)
);

// File: tb/tb_cmp_pin_unit.sv
module tb_cmp_pin_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       matchPulse = 1'b0, bottomEvt = 1'b0, countDown = 1'b0;
  logic [1:0] modeClass = 2'd0, comField = 2'd0;
  logic       forceStrobe = 1'b0, portData = 1'b0, portDir = 1'b0;
  logic       pinOut, pinOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [1:0] expQ[$];
  string      tagQ[$];

  logic [1:0] mCom = 2'd0;
  logic       mOc  = 1'b0;

  always #5 clk = ~clk;

  cmp_pin_unit dut (
    .clk(clk), .rstN(rstN), .matchPulse(matchPulse), .bottomEvt(bottomEvt),
    .countDown(countDown), .modeClass(modeClass), .comField(comField),
    .forceStrobe(forceStrobe), .portData(portData), .portDir(portDir),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  // reference behaviour derived from the requirements
  function automatic void modelEdge();
    if (!rstN) begin
      mCom = 2'd0;
      mOc  = 1'b0;
      return;
    end
    case (modeClass)
      2'd0: if (matchPulse || forceStrobe) begin
        if (mCom == 2'd1) mOc = ~mOc;
        else if (mCom == 2'd2) mOc = 1'b0;
        else if (mCom == 2'd3) mOc = 1'b1;
      end
      2'd1: begin
        if (matchPulse) begin
          if (mCom == 2'd2) mOc = 1'b0;
          else if (mCom == 2'd3) mOc = 1'b1;
        end else if (bottomEvt) begin
          if (mCom == 2'd2) mOc = 1'b1;
          else if (mCom == 2'd3) mOc = 1'b0;
        end
      end
      2'd2: if (matchPulse) begin
        if (mCom == 2'd2) mOc = countDown;
        else if (mCom == 2'd3) mOc = ~countDown;
      end
      default: ;
    endcase
    mCom = comField;
  endfunction

  task automatic step(input logic rs, input logic [1:0] cls, input logic [1:0] fld,
                      input logic m, input logic b, input logic dn, input logic f,
                      input logic pd, input logic pe, input string tag);
    @(negedge clk);
    rstN = rs; modeClass = cls; comField = fld; matchPulse = m; bottomEvt = b;
    countDown = dn; forceStrobe = f; portData = pd; portDir = pe;
    modelEdge();
    expQ.push_back({(mCom != 2'd0) ? mOc : pd, pe});
    tagQ.push_back(tag);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if ({pinOut, pinOe} !== e) begin
          errors++;
          $display("FAIL %s: {pinOut,pinOe} actual=%b expected=%b at %0t", t, {pinOut, pinOe}, e, $time);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(0, 0, 2'd3, 1, 0, 0, 1, 1, 0, "R1");
    step(0, 0, 2'd3, 1, 0, 0, 1, 0, 1, "R1");
    step(1, 0, 2'd0, 0, 0, 0, 0, 1, 1, "R1");
    // R2 / R3 / R4 field off: pin follows port, matches ignored
    step(1, 0, 2'd0, 1, 0, 0, 0, 0, 1, "R4");
    step(1, 0, 2'd0, 1, 1, 0, 1, 1, 0, "R3");
    step(1, 1, 2'd0, 1, 1, 0, 0, 0, 1, "R4");
    step(1, 0, 2'd0, 0, 0, 0, 0, 1, 1, "R2");
    // R5 plain toggle / clear / set
    step(1, 0, 2'd1, 0, 0, 0, 0, 1, 1, "R2");
    step(1, 0, 2'd1, 1, 0, 0, 0, 0, 1, "R5");
    step(1, 0, 2'd1, 1, 0, 0, 0, 0, 1, "R5");
    step(1, 0, 2'd1, 1, 0, 0, 0, 1, 1, "R5");
    step(1, 0, 2'd1, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 0, 2'd2, 0, 0, 0, 0, 0, 1, "R5");
    step(1, 0, 2'd2, 1, 0, 0, 0, 1, 1, "R5");
    step(1, 0, 2'd3, 0, 0, 0, 0, 0, 1, "R5");
    step(1, 0, 2'd3, 1, 0, 0, 0, 0, 1, "R5");
    // R11 field written with a match: old field acts
    step(1, 0, 2'd2, 1, 0, 0, 0, 0, 1, "R11");
    step(1, 0, 2'd2, 0, 0, 0, 0, 0, 1, "R11");
    step(1, 0, 2'd2, 1, 0, 0, 0, 0, 1, "R11");
    // R6 force in plain class, and force + match toggles once
    step(1, 0, 2'd3, 0, 0, 0, 0, 0, 1, "R6");
    step(1, 0, 2'd1, 0, 0, 0, 1, 0, 1, "R6");
    step(1, 0, 2'd1, 0, 0, 0, 1, 0, 1, "R6");
    step(1, 0, 2'd1, 1, 0, 0, 1, 0, 1, "R6");
    step(1, 0, 2'd1, 1, 0, 0, 1, 0, 1, "R6");
    // R7 single slope
    step(1, 1, 2'd2, 0, 1, 0, 0, 0, 1, "R7");
    step(1, 1, 2'd2, 1, 0, 0, 0, 1, 1, "R7");
    step(1, 1, 2'd2, 0, 1, 0, 0, 0, 1, "R7");
    step(1, 1, 2'd3, 1, 1, 0, 0, 0, 1, "R7");
    step(1, 1, 2'd3, 1, 1, 0, 0, 0, 1, "R7");
    step(1, 1, 2'd3, 0, 1, 0, 0, 1, 1, "R7");
    step(1, 1, 2'd2, 1, 0, 0, 0, 0, 1, "R7");
    step(1, 1, 2'd2, 1, 1, 0, 0, 0, 1, "R7");
    // R8 single slope field 1
    step(1, 1, 2'd1, 0, 1, 0, 0, 0, 1, "R8");
    step(1, 1, 2'd1, 1, 0, 0, 0, 0, 1, "R8");
    step(1, 1, 2'd1, 0, 1, 0, 1, 0, 1, "R8");
    // R9 dual slope
    step(1, 2, 2'd2, 0, 0, 0, 0, 0, 1, "R9");
    step(1, 2, 2'd2, 1, 0, 1, 0, 0, 1, "R9");
    step(1, 2, 2'd2, 1, 0, 0, 0, 0, 1, "R9");
    step(1, 2, 2'd2, 0, 1, 0, 0, 0, 1, "R9");
    step(1, 2, 2'd3, 1, 0, 1, 0, 0, 1, "R9");
    step(1, 2, 2'd3, 1, 0, 0, 0, 0, 1, "R9");
    step(1, 2, 2'd3, 1, 0, 1, 0, 0, 1, "R9");
    step(1, 2, 2'd3, 0, 1, 0, 0, 0, 1, "R9");
    // R10 force ignored in PWM classes
    step(1, 2, 2'd1, 0, 0, 0, 1, 0, 1, "R10");
    step(1, 2, 2'd1, 0, 0, 0, 1, 0, 1, "R10");
    step(1, 1, 2'd3, 0, 0, 0, 1, 0, 1, "R10");
    step(1, 1, 2'd3, 0, 0, 0, 1, 1, 1, "R10");
    // R13 reserved class
    step(1, 3, 2'd1, 1, 1, 0, 1, 0, 1, "R13");
    step(1, 3, 2'd1, 1, 1, 1, 1, 0, 1, "R13");
    // R12 initialise while input, then enable
    step(1, 0, 2'd2, 0, 0, 0, 0, 1, 0, "R12");
    step(1, 0, 2'd2, 0, 0, 0, 1, 1, 0, "R12");
    step(1, 0, 2'd3, 0, 0, 0, 0, 1, 0, "R12");
    step(1, 0, 2'd3, 0, 0, 0, 1, 0, 0, "R12");
    step(1, 0, 2'd3, 0, 0, 0, 0, 0, 1, "R12");
    // R1 asynchronous reset mid-run
    step(0, 0, 2'd3, 0, 0, 0, 0, 0, 1, "R1");
    step(1, 0, 2'd0, 0, 0, 0, 0, 1, 1, "R1");
    @(negedge clk);
    @(posedge clk);
    #4;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule